// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs one Clause-22 management transaction at a time on an MDIO bus. It derives the management clock (MDC) from the system clock with a 16-bit programmable divider. It shifts out a 32-bit all-ones preamble followed by the 32-bit frame. On a read it releases the data line at turnaround and shifts in the PHY's 16-bit response.

Control logic elsewhere does the register decoding, arbitration and PHY polling. That logic pulses `start` together with a read/write flag, the PHY and register addresses, the write data and the divider value. It then waits for the one-cycle `done` pulse. At that pulse the read data and the acknowledge flag are valid, and they hold until the next transaction completes.

The bidirectional pin is presented as separate output, output-enable and input signals, so a pad cell can be attached outside the block.

Top module: `mdio_frame_engine`

## Requirements
- R1: While reset is active and after it, before any start, `mdc`, `mdio_oe`, `mdio_o`, `done`, `busy` and `ack` are all 0, and `rd_data` is 0.
- R2: While busy, `mdc` has a period of (clk_div+1) system clocks, with its low phase first, and a `clk_div` of 0 behaves as 1. While idle, `mdc` stays low. The divider value is sampled when `start` is accepted.
- R3: Every frame begins with 32 consecutive preamble bits of value 1, driven with `mdio_oe` high.
- R4: After the preamble, the block sends the start pattern 01, then the opcode, then the 5-bit PHY address and then the 5-bit register address. The opcode is 10 for a read (`rd_wr`=1) and 01 for a write. All fields go MSB first.
- R5: On a write, the block drives the turnaround bits 10, then the 16 data bits MSB first, and keeps `mdio_oe` high for all 64 bits.
- R6: On a read, `mdio_oe` is low from the first turnaround bit (bit 46 of the 64 bits) through the end of the frame.
- R7: `ack` is 1 at `done` only for a read in which `mdio_i` was 0 when sampled for the second turnaround bit. A write always reports `ack` = 0. When `ack` is 0 after a read, the data is to be treated as invalid.
- R8: On a read, the block samples `mdio_i` on each MDC rising edge over the last 16 bits and presents the value MSB first on `rd_data`. A write sets `rd_data` to 0.
- R9: While busy, `mdio_o` changes only in the cycle in which `mdc` falls.
- R10: `done` is a single-cycle pulse. It comes exactly 64*(max(clk_div,1)+1) clock edges after the edge that accepts `start`, and `busy` falls with it.
- R11: A `start` pulse while busy is ignored. The frame in flight, its timing and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| rd_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| clk_div | input | 16 | MDC divider; period = clk_div+1 clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ack | output | 1 | PHY acknowledged the read |
| rd_data | output | 16 | Data returned by the read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The only timed result is `done`, together with `ack` and `rd_data`, which become valid on the same edge. It is due exactly 64*(max(clk_div,1)+1) edges after the accepting edge. The bench counts falling clock edges from the first one after acceptance and expects to see `done` at exactly that count, then low one cycle later.

Frame bits are captured on each rising edge of `mdc`, where the enable and data are settled. A PHY model changes `mdio_i` only on falling edges of `mdc`, so each bit is stable for a full low phase before the block samples it. All signals are read on the falling system-clock edge, away from the edge where the registers update.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    parameter int ADDR_W    = 5;
    parameter int DATA_W    = 16;
    parameter int PRE_BITS  = 32;
    localparam int FRM_BITS  = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TOTAL     = PRE_BITS + FRM_BITS;
    localparam int IDX_W     = $clog2(TOTAL + 1);
    localparam int REL_IDX   = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int ACK_IDX   = REL_IDX + 1;
    localparam int DATA_IDX  = REL_IDX + 2;
    localparam int LAST_IDX  = TOTAL - 1;

    localparam logic [1:0] SOF   = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] TA_WR = 2'b10;

    function automatic logic [FRM_BITS-1:0] build_frame(
        input logic              is_rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] rg,
        input logic [DATA_W-1:0] wd
    );
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] dat;
        op  = is_rd ? OP_RD : OP_WR;
        ta  = is_rd ? 2'b11 : TA_WR;
        dat = is_rd ? '0 : wd;
        return {SOF, op, phy, rg, ta, dat};
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t q, d;
    logic [DIV_W-1:0] eff;
    logic [DIV_W:0]   half_m1;

    always_comb begin
        eff     = (div == '0) ? DIV_W'(1) : div;
        half_m1 = (({1'b0, eff} + 1'b1) >> 1) - 1'b1;
        rise    = run && ({1'b0, q.cnt} == half_m1);
        fall    = run && (q.cnt == eff);
        d       = q;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else begin
            d.cnt = fall ? '0 : q.cnt + 1'b1;
            if (rise) d.mdc = 1'b1;
            if (fall) d.mdc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.cnt <= eff));
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!q.mdc && q.cnt == '0));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic [DIV_W-1:0]  div_lat,
    output logic              done,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    typedef struct packed {
        logic                busy;
        logic                rd;
        logic [IDX_W-1:0]    idx;
        logic [FRM_BITS-1:0] frame;
        logic [DATA_W-1:0]   rd_sh;
        logic                ack_s;
        logic [DATA_W-1:0]   rdata;
        logic                ack;
        logic                done;
        logic                o;
        logic                oe;
        logic [DIV_W-1:0]    div;
    } seq_t;

    seq_t q, d;
    logic [IDX_W-1:0] nxt;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        nxt    = q.idx + 1'b1;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.rd    = rd_wr;
                d.idx   = '0;
                d.frame = build_frame(rd_wr, phy_addr, reg_addr, wr_data);
                d.div   = clk_div;
                d.rd_sh = '0;
                d.ack_s = 1'b0;
                d.o     = 1'b1;
                d.oe    = 1'b1;
            end
        end else begin
            if (rise && q.rd) begin
                if (q.idx == IDX_W'(ACK_IDX)) d.ack_s = ~mdio_i;
                if (q.idx >= IDX_W'(DATA_IDX)) d.rd_sh = {q.rd_sh[DATA_W-2:0], mdio_i};
            end
            if (fall) begin
                if (q.idx == IDX_W'(LAST_IDX)) begin
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                    d.o     = 1'b0;
                    d.oe    = 1'b0;
                    d.ack   = q.rd & q.ack_s;
                    d.rdata = q.rd ? q.rd_sh : '0;
                end else begin
                    d.idx = nxt;
                    if (nxt >= IDX_W'(PRE_BITS)) begin
                        d.o     = q.frame[FRM_BITS-1];
                        d.frame = q.frame << 1;
                    end else begin
                        d.o = 1'b1;
                    end
                    d.oe = !(q.rd && nxt >= IDX_W'(REL_IDX));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign div_lat = q.div;
    assign done    = q.done;
    assign ack     = q.ack;
    assign rd_data = q.rdata;
    assign mdio_o  = q.o;
    assign mdio_oe = q.oe;

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.busy && $past(q.busy)));
    p_write_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.rd) |-> (!q.ack && q.rdata == '0));
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start && !fall) |=> ($stable(q.idx) && $stable(q.frame)));
    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> $stable(q.rd));
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.rd && q.idx >= IDX_W'(ACK_IDX)) |-> !q.oe);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              busy,
    output logic              done,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic             rise_w;
    logic             fall_w;
    logic [DIV_W-1:0] div_w;

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_gen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (div_w),
        .mdc  (mdc),
        .rise (rise_w),
        .fall (fall_w)
    );

    mdio_frame_seq #(.DIV_W(DIV_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rd_wr   (rd_wr),
        .phy_addr(phy_addr),
        .reg_addr(reg_addr),
        .wr_data (wr_data),
        .clk_div (clk_div),
        .rise    (rise_w),
        .fall    (fall_w),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .div_lat (div_w),
        .done    (done),
        .ack     (ack),
        .rd_data (rd_data),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    p_out_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));
    p_oe_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);
    p_mdc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
endmodule

// File: tb/mdio_frame_engine_bench.sv
module mdio_frame_engine_bench;
    typedef struct packed {
        logic        rw;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] data;
        logic [15:0] div;
        logic        acken;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'h01, 5'h00, 16'h1234, 16'd1, 1'b0},
        '{1'b1, 5'h1F, 5'h1F, 16'hBEEF, 16'd0, 1'b1},
        '{1'b0, 5'h10, 5'h15, 16'hA5C3, 16'd3, 1'b0},
        '{1'b1, 5'h05, 5'h02, 16'h8001, 16'd4, 1'b0},
        '{1'b1, 5'h00, 5'h11, 16'hFFFF, 16'd2, 1'b1},
        '{1'b0, 5'h1A, 5'h0A, 16'h0000, 16'd5, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, rd_wr = 1'b0;
    logic [4:0] phy_addr = '0, reg_addr = '0;
    logic [15:0] wr_data = '0, clk_div = 16'd1;
    logic busy, done, ack, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic mdio_i = 1'b1;

    int checks = 0;
    int fails = 0;

    mdio_frame_engine u_mdio_frame_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_wr(rd_wr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .clk_div(clk_div), .busy(busy), .done(done), .ack(ack),
        .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    // PHY model: capture on MDC rise, drive response on MDC fall
    int phy_bit = 0;
    logic phy_rd = 1'b0, phy_ack = 1'b0;
    logic [15:0] phy_data = '0;
    logic [63:0] cap_o, cap_oe;
    int clk_cnt = 0, last_rise = 0, rise_gap = 0;

    always @(negedge clk) clk_cnt <= clk_cnt + 1;

    always @(posedge mdc) begin
        if (phy_bit < 64) begin
            cap_o[63-phy_bit]  = mdio_o;
            cap_oe[63-phy_bit] = mdio_oe;
        end
        phy_bit   = phy_bit + 1;
        rise_gap  = clk_cnt - last_rise;
        last_rise = clk_cnt;
    end

    always @(negedge mdc) begin
        if (phy_rd && phy_bit == 47)                      mdio_i = ~phy_ack;
        else if (phy_rd && phy_bit >= 48 && phy_bit < 64) mdio_i = phy_data[63-phy_bit];
        else                                              mdio_i = 1'b1;
    end

    // R9 monitor: output may only change when MDC falls
    int r9_viol = 0;
    logic p_busy = 1'b0, p_mdc = 1'b0, p_o = 1'b0;
    always @(negedge clk) begin
        if (busy && p_busy && mdio_o != p_o && !(p_mdc && !mdc)) r9_viol++;
        p_busy = busy; p_mdc = mdc; p_o = mdio_o;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input vec_t v);
        return {32'hFFFF_FFFF, 2'b01, (v.rw ? 2'b10 : 2'b01), v.phy, v.rg, 2'b10, v.data};
    endfunction

    task automatic run_vec(input vec_t v, input int intr_at);
        int cyc;
        int eff;
        logic [63:0] ef;
        eff = (v.div == 0) ? 1 : int'(v.div);
        ef  = exp_frame(v);
        phy_bit = 0; phy_rd = v.rw; phy_ack = v.acken; phy_data = v.data;
        @(negedge clk);
        start = 1'b1; rd_wr = v.rw; phy_addr = v.phy; reg_addr = v.rg;
        wr_data = v.data; clk_div = v.div;
        @(negedge clk);
        start = 1'b0; rd_wr = ~v.rw; phy_addr = ~v.phy; wr_data = ~v.data; clk_div = 16'd7;
        cyc = 0;
        while (!done && cyc < 70000) begin
            @(negedge clk);
            cyc++;
            if (intr_at != 0 && cyc == intr_at) start = 1'b1;
            if (intr_at != 0 && cyc == intr_at + 1) start = 1'b0;
        end
        chk(cyc == 64 * (eff + 1), "R10 done latency", 64'(cyc), 64'(64 * (eff + 1)));
        chk(!busy, "R10 busy falls with done", 64'(busy), 64'd0);
        chk(cap_o[63:32] == 32'hFFFF_FFFF && cap_oe[63:32] == 32'hFFFF_FFFF,
            "R3 preamble", {cap_o[63:32], cap_oe[63:32]}, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(cap_o[31:18] == ef[31:18] && cap_oe[31:18] == 14'h3FFF,
            "R4 start/opcode/addresses", 64'(cap_o[31:18]), 64'(ef[31:18]));
        if (!v.rw) begin
            chk(cap_o[17:0] == ef[17:0] && cap_oe[17:0] == 18'h3FFFF,
                "R5 write turnaround and data", 64'(cap_o[17:0]), 64'(ef[17:0]));
            chk(ack == 1'b0, "R7 write ack", 64'(ack), 64'd0);
            chk(rd_data == 16'h0, "R8 write rd_data", 64'(rd_data), 64'd0);
        end else begin
            chk(cap_oe[17:0] == 18'h0, "R6 read releases line", 64'(cap_oe[17:0]), 64'd0);
            chk(ack == v.acken, "R7 read ack", 64'(ack), 64'(v.acken));
            chk(rd_data == v.data, "R8 read data", 64'(rd_data), 64'(v.data));
        end
        chk(rise_gap == eff + 1, "R2 mdc period", 64'(rise_gap), 64'(eff + 1));
        @(negedge clk);
        chk(!done, "R10 done single cycle", 64'(done), 64'd0);
        chk(!mdc && !mdio_oe, "R2 mdc idle low", {62'd0, mdc, mdio_oe}, 64'd0);
        rd_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mdc && !mdio_oe && !mdio_o && !done && !busy && !ack && rd_data == 0,
            "R1 reset state", {46'd0, rd_data, mdc, mdio_oe, done, busy, ack, mdio_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!mdc && !busy && !mdio_oe, "R1 idle after reset", {61'd0, mdc, busy, mdio_oe}, 64'd0);
        for (int i = 0; i < NV; i++) run_vec(VEC[i], 0);
        // R11: start pulse mid-frame must not disturb the frame
        run_vec('{1'b0, 5'h0C, 5'h03, 16'h5A5A, 16'd2, 1'b0}, 50);
        run_vec('{1'b1, 5'h07, 5'h09, 16'h0F0F, 16'd1, 1'b1}, 100);
        chk(r9_viol == 0, "R9 output changes only at mdc fall", 64'(r9_viol), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule